// File: doc/BRIEF.md
# Internal-Clock Successive-Approximation Conversion and Readout Engine

This block sequences a 16-step successive-approximation conversion, or a long calibration run, from a free-running internal conversion tick. It does not use the host's serial clock for this work. A single-cycle start strobe launches the operation, and a select input chooses between converting and calibrating. While the engine is busy, the status strobe is held low. It returns high in the cycle that the work completes.

A finished conversion is latched into a holding register and into a readout shifter. The most significant bit is presented on the serial data output at once. The host then reads the remaining bits whenever it likes, by producing falling edges on its serial clock with chip select low. Chip select plays no part in the conversion itself.

A fresh start strobe always wins. It aborts whatever is running and begins anew. An aborted conversion never disturbs the stored result. The analog side is abstracted away: the engine presents a trial code to an external DAC and comparator and receives one comparison bit back. Calibration is reduced to a tick counter whose length is a parameter.

Top module: `sar_int_engine`

## Requirements
- R1: After reset, sstrb is 1, holdData is 0 and dout is 0.
- R2: In the cycle after a start strobe (conversion or calibration), sstrb is 0. It stays 0 until that operation completes.
- R3: A conversion consumes exactly DATA_W cycles with intClkEn high. Bits are decided MSB first. During a step, dacCode equals the bits kept so far with the current trial bit set. A compBit of 1 keeps the trial bit. The first trial code after a start is 0x8000.
- R4: On the last conversion step, holdData takes the converted value, sstrb rises and dout shows the MSB. All three change on the same clock edge.
- R5: Each falling edge of sclk sampled with csN low and the engine idle shifts the readout left by one. dout then shows the next lower bit. After all bits have been shifted out, dout reads 0.
- R6: sclk falling edges are ignored while csN is high or while a conversion or calibration is running.
- R7: csN has no effect on conversion progress or on sstrb. sstrb is always driven.
- R8: A calibration holds sstrb low for exactly CAL_TICKS intClkEn cycles. It leaves holdData and the readout state unchanged.
- R9: A start strobe during a conversion or calibration aborts it and restarts the count. An aborted conversion leaves holdData unchanged.
- R10: When a start strobe and intClkEn are high in the same cycle, the start wins. That tick is not counted toward the new operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| intClkEn | input | 1 | Internal conversion tick enable |
| startStrobe | input | 1 | One-cycle start of an operation |
| startCal | input | 1 | 1 selects calibration, 0 selects conversion (sampled with startStrobe) |
| compBit | input | 1 | Comparator result for the current dacCode (1 = input at or above code) |
| csN | input | 1 | Active-low chip select for readout |
| sclk | input | 1 | Host serial clock, synchronous to clk |
| sstrb | output | 1 | Status: 0 while busy, 1 when idle |
| dout | output | 1 | Serial readout bit |
| dacCode | output | DATA_W | Trial code presented to the DAC |
| holdData | output | DATA_W | Last completed conversion result |

## Verification
The assertions assume three things about the inputs. First, sclk and csN are already synchronous to clk. Second, compBit settles within the same cycle that dacCode changes. Third, startStrobe is a single-cycle pulse and startCal is meaningful only alongside it.

The bench drives every input at the falling edge of clk. It derives compBit combinationally from dacCode and a fixed analog value, and it holds the analog value constant for the length of each conversion it expects to finish. Ticks, serial clock activity and chip-select levels are varied between runs. Aborts are placed both mid-conversion and in the same cycle as a tick.

// File: rtl/sar_int_pkg.sv
package sar_int_pkg;
  typedef struct packed {
    logic clearSar;
    logic sarStep;
    logic commit;
    logic shiftOut;
    logic convActive;
  } ctlStrobes_t;
endpackage

// File: rtl/sar_int_ctrl.sv
module sar_int_ctrl
  import sar_int_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int CAL_TICKS = 80000
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      intClkEn,
  input  logic                      startStrobe,
  input  logic                      startCal,
  input  logic                      csN,
  input  logic                      sclk,
  output logic                      sstrb,
  output ctlStrobes_t               ctl,
  output logic [$clog2(DATA_W)-1:0] bitIdx
);
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int MAXC   = (CAL_TICKS > DATA_W) ? CAL_TICKS : DATA_W;
  localparam int CNT_W  = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] LAST_CONV = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_CAL  = CNT_W'(CAL_TICKS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_CONV, ST_CAL} state_t;

  state_t           state;
  logic [CNT_W-1:0] stepCnt;
  logic             sstrbReg;
  logic             sclkQ;
  logic             sclkFall;

  assign sclkFall = sclkQ && !sclk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      stepCnt  <= '0;
      sstrbReg <= 1'b1;
      sclkQ    <= 1'b0;
    end else begin
      sclkQ <= sclk;
      if (startStrobe) begin
        state    <= startCal ? ST_CAL : ST_CONV;
        stepCnt  <= '0;
        sstrbReg <= 1'b0;
      end else if (intClkEn) begin
        unique case (state)
          ST_CONV: begin
            if (stepCnt == LAST_CONV) begin
              state    <= ST_IDLE;
              stepCnt  <= '0;
              sstrbReg <= 1'b1;
            end else begin
              stepCnt <= stepCnt + 1'b1;
            end
          end
          ST_CAL: begin
            if (stepCnt == LAST_CAL) begin
              state    <= ST_IDLE;
              stepCnt  <= '0;
              sstrbReg <= 1'b1;
            end else begin
              stepCnt <= stepCnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    ctl.clearSar   = startStrobe;
    ctl.convActive = (state == ST_CONV);
    ctl.sarStep    = ctl.convActive && intClkEn && !startStrobe;
    ctl.commit     = ctl.sarStep && (stepCnt == LAST_CONV);
    ctl.shiftOut   = (state == ST_IDLE) && !startStrobe && sclkFall && !csN;
  end

  assign bitIdx = IDX_W'(DATA_W - 1) - stepCnt[IDX_W-1:0];
  assign sstrb  = sstrbReg;

  // R2: a start always pulls the status low on the next edge
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    startStrobe |=> !sstrb);

  // R10: status can only rise on an edge that saw a tick and no start
  p_rise_needs_tick_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sstrb) |-> ($past(intClkEn) && !$past(startStrobe)));

  // R6: no readout shift is requested while busy
  p_no_shift_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.shiftOut |-> sstrb);

  // R3: SAR steps only while status shows busy
  p_step_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.sarStep |-> !sstrb);
endmodule

// File: rtl/sar_int_datapath.sv
module sar_int_datapath
  import sar_int_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctlStrobes_t               ctl,
  input  logic [$clog2(DATA_W)-1:0] bitIdx,
  input  logic                      compBit,
  output logic [DATA_W-1:0]         dacCode,
  output logic [DATA_W-1:0]         holdData,
  output logic                      dout
);
  logic [DATA_W-1:0] sarReg;
  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] trialWord;
  logic [DATA_W-1:0] nextSar;

  assign trialWord = sarReg | (DATA_W'(1) << bitIdx);
  assign nextSar   = compBit ? trialWord : sarReg;
  assign dacCode   = ctl.convActive ? trialWord : sarReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sarReg   <= '0;
      holdReg  <= '0;
      shiftReg <= '0;
    end else begin
      if (ctl.clearSar) begin
        sarReg <= '0;
      end else if (ctl.sarStep) begin
        sarReg <= nextSar;
      end
      if (ctl.commit) begin
        holdReg  <= nextSar;
        shiftReg <= nextSar;
      end else if (ctl.shiftOut) begin
        shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign holdData = holdReg;
  assign dout     = shiftReg[DATA_W-1];

  // R9: the stored result moves only on a committing step
  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.commit |=> $stable(holdData));

  // R6: readout frozen unless shifted or reloaded
  p_shift_frozen_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.commit && !ctl.shiftOut) |=> $stable(dout));

  // R4: commit and shift request never coincide
  p_commit_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.commit && ctl.shiftOut));
endmodule

// File: rtl/sar_int_engine.sv
module sar_int_engine
  import sar_int_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int CAL_TICKS = 80000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              intClkEn,
  input  logic              startStrobe,
  input  logic              startCal,
  input  logic              compBit,
  input  logic              csN,
  input  logic              sclk,
  output logic              sstrb,
  output logic              dout,
  output logic [DATA_W-1:0] dacCode,
  output logic [DATA_W-1:0] holdData
);
  ctlStrobes_t               ctl;
  logic [$clog2(DATA_W)-1:0] bitIdx;

  sar_int_ctrl #(.DATA_W(DATA_W), .CAL_TICKS(CAL_TICKS)) uCtrl (
    .clk(clk), .rstN(rstN), .intClkEn(intClkEn), .startStrobe(startStrobe),
    .startCal(startCal), .csN(csN), .sclk(sclk), .sstrb(sstrb),
    .ctl(ctl), .bitIdx(bitIdx)
  );

  sar_int_datapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .bitIdx(bitIdx), .compBit(compBit),
    .dacCode(dacCode), .holdData(holdData), .dout(dout)
  );
endmodule

// File: tb/tb_sar_int_engine.sv
`timescale 1ns/1ps
module tb_sar_int_engine;
  localparam int W   = 16;
  localparam int CAL = 40;

  logic clk = 0, rstN = 0;
  logic intClkEn = 0, startStrobe = 0, startCal = 0, csN = 1, sclk = 0;
  logic compBit, sstrb, dout;
  logic [W-1:0] dacCode, holdData;
  logic [W-1:0] analogVal = '0;
  int nChecks = 0, nFail = 0, cycles = 0;

  always #10 clk = ~clk;
  assign compBit = (dacCode <= analogVal);

  sar_int_engine #(.DATA_W(W), .CAL_TICKS(CAL)) dut (
    .clk(clk), .rstN(rstN), .intClkEn(intClkEn), .startStrobe(startStrobe),
    .startCal(startCal), .compBit(compBit), .csN(csN), .sclk(sclk),
    .sstrb(sstrb), .dout(dout), .dacCode(dacCode), .holdData(holdData));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  int mState = 0, mCnt = 0;
  logic mSstrb = 1, mPrev = 0;
  logic [W-1:0] mHold = '0, mShift = '0;
  always @(posedge clk) begin
    logic fall;
    if (!rstN) begin
      mState = 0; mCnt = 0; mSstrb = 1; mHold = '0; mShift = '0; mPrev = 0;
    end else begin
      fall = mPrev && !sclk;
      mPrev = sclk;
      if (startStrobe) begin
        mState = startCal ? 2 : 1; mCnt = 0; mSstrb = 0;
      end else if (mState != 0 && intClkEn) begin
        mCnt++;
        if (mState == 1 && mCnt == W) begin
          mState = 0; mSstrb = 1; mHold = analogVal; mShift = analogVal;
        end else if (mState == 2 && mCnt == CAL) begin
          mState = 0; mSstrb = 1;
        end
      end else if (mState == 0 && fall && !csN) begin
        mShift = mShift << 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      check(sstrb === mSstrb, "R2 sstrb per-cycle", 32'(sstrb), 32'(mSstrb));
      check(holdData === mHold, "R4 holdData per-cycle", 32'(holdData), 32'(mHold));
      check(dout === mShift[W-1], "R5 dout per-cycle", 32'(dout), 32'(mShift[W-1]));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

  task automatic step(input logic st, input logic cal, input logic tk, input logic cs, input logic sc);
    @(negedge clk);
    startStrobe = st; startCal = cal; intClkEn = tk; csN = cs; sclk = sc;
    @(posedge clk);
    #2;
  endtask

  // R3/R4/R7/R10: run a conversion to completion, counting ticks
  task automatic convRun(input logic [W-1:0] v, input int every, input logic cs,
                         input bit toggleSclk, input bit tickAtStart);
    int ticks = 0;
    analogVal = v;
    step(1, 0, tickAtStart, cs, 0);
    check(sstrb == 0, "R2 low after start", 32'(sstrb), 0);
    check(dacCode == 16'h8000, "R3 first trial code", 32'(dacCode), 32'h8000);
    for (int i = 0; i < 2000 && sstrb == 0; i++) begin
      logic tk = ((i % every) == every - 1);
      step(0, 0, tk, cs, toggleSclk ? logic'(i % 2) : 1'b0);
      if (tk) ticks++;
    end
    check(ticks == W, "R3 R10 tick count", 32'(ticks), 32'(W));
    check(holdData == v, "R4 result latched", 32'(holdData), 32'(v));
    check(dout == v[W-1], "R4 MSB on dout", 32'(dout), 32'(v[W-1]));
  endtask

  task automatic readout(input logic [W-1:0] v, input int n, input logic cs);
    for (int k = 1; k <= n; k++) begin
      logic exp;
      step(0, 0, 0, cs, 1);
      step(0, 0, 0, cs, 0);
      exp = cs ? v[W-1] : ((k < W) ? v[W-1-k] : 1'b0);
      check(dout == exp, cs ? "R6 csN high ignores sclk" : "R5 readout bit", 32'(dout), 32'(exp));
    end
  endtask

  task automatic calRun(input logic [W-1:0] holdExp, input logic doutExp);
    int ticks = 0;
    step(1, 1, 0, 0, 0);
    check(sstrb == 0, "R2 low after cal start", 32'(sstrb), 0);
    for (int i = 0; i < 2000 && sstrb == 0; i++) begin
      logic tk = (i % 2 == 1);
      step(0, 0, tk, 0, logic'(i % 2));
      if (tk) ticks++;
    end
    check(ticks == CAL, "R8 cal tick count", 32'(ticks), 32'(CAL));
    check(holdData == holdExp, "R8 hold kept over cal", 32'(holdData), 32'(holdExp));
    check(dout == doutExp, "R8 readout kept over cal", 32'(dout), 32'(doutExp));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(posedge clk); #2;
    check(sstrb == 1, "R1 reset sstrb", 32'(sstrb), 1);
    check(holdData == 0, "R1 reset hold", 32'(holdData), 0);
    check(dout == 0, "R1 reset dout", 32'(dout), 0);

    // R7: csN high during conversion
    convRun(16'hA5C3, 3, 1, 0, 0);
    readout(16'hA5C3, 3, 1);
    readout(16'hA5C3, 18, 0);

    // R6: sclk toggling with csN low during conversion, R10 start with tick
    convRun(16'h7FFE, 2, 0, 1, 1);
    readout(16'h7FFE, 4, 0);
    convRun(16'h0000, 1, 0, 0, 0);
    convRun(16'hFFFF, 1, 1, 0, 0);

    // R9: abort mid-conversion, hold keeps old value
    analogVal = 16'h1234;
    step(1, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) step(0, 0, 1, 0, 0);
    check(holdData == 16'hFFFF, "R9 hold kept during abort", 32'(holdData), 32'hFFFF);
    convRun(16'h8001, 2, 0, 0, 0);

    // R9/R8: conversion aborted by calibration
    readout(16'h8001, 2, 0);
    analogVal = 16'h0F0F;
    step(1, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 0);
    calRun(16'h8001, 1'b0);
    check(holdData == 16'h8001, "R9 abort by cal keeps hold", 32'(holdData), 32'h8001);
    calRun(16'h8001, 1'b0);
    convRun(16'h3C5A, 4, 1, 1, 0);
    readout(16'h3C5A, 17, 0);

    repeat (3) step(0, 0, 0, 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule